// File: doc/BRIEF.md
# Timer Capture and Compare Unit

This unit sits beside a free-running timer counter and serves it in one of two ways, picked by a 4-bit mode code. In capture mode it watches an external input pin, synchronizes it, detects edges, and on a qualifying edge stores the timer value it sees into a capture register. A qualifying edge is one falling edge, one rising edge, or every 4th or every 16th rising edge.

In compare mode it holds a value written by software and watches for the first cycle in which the timer equals that value. On that cycle it drives its output pin high, drives it low, or inverts it. In the special-event variant it leaves the pin alone and pulses a request that makes the timer clear itself. That request is separate from the timer's own overflow interrupt. Every capture or compare event also sets one sticky event flag, which software clears.

Top module: `cap_cmp_unit`

## Requirements
- R1: After reset, `pin_out`, `flag`, `tmr_clr`, `cap_val` and `cmp_val` are all zero.
- R2: Mode 4'b0100 stores `tmr_val` into `cap_val` and sets `flag` on each falling edge of `pin_in`. The store uses the timer value present at the third rising clock edge after the pin changes.
- R3: Mode 4'b0101 does the same on each rising edge of `pin_in`, with the same latency.
- R4: Mode 4'b0110 captures only on every 4th synchronized rising edge of `pin_in`. The first three rising edges leave `cap_val` and `flag` unchanged.
- R5: Mode 4'b0111 captures only on every 16th synchronized rising edge of `pin_in`.
- R6: Any change of `mode` clears the rising-edge prescale count. After a change, a capture needs a full 4 or 16 new rising edges.
- R7: Mode 4'b1000 sets `pin_out` high and sets `flag` one clock after `tmr_val` first equals `cmp_val`.
- R8: Mode 4'b1001 drives `pin_out` low and sets `flag` one clock after the first cycle of a match.
- R9: Mode 4'b1010 inverts `pin_out` once per match episode. A match that lasts several cycles inverts the pin only once.
- R10: Mode 4'b1011 pulses `tmr_clr` high for exactly one clock after the first cycle of a match, sets `flag`, and leaves `pin_out` unchanged.
- R11: `flag` stays set until `flag_clr` is high at a clock edge. If an event arrives in the same cycle as `flag_clr`, the flag stays set.
- R12: Mode 4'b0000, and any code not listed above (for example 4'b0011), drives `pin_out` low. In these modes no edge on `pin_in` changes `cap_val` or `flag`.
- R13: `cmp_wr` high at a clock edge loads `cmp_wdata` into the compare register, which reads back on `cmp_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Current value of the free-running timer |
| pin_in | input | 1 | Asynchronous capture input pin |
| mode | input | 4 | Operating mode code |
| cmp_wr | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 16 | Compare value to write |
| flag_clr | input | 1 | Clears the sticky event flag |
| pin_out | output | 1 | Compare output pin latch |
| cap_val | output | 16 | Captured timer value |
| cmp_val | output | 16 | Compare register read-back |
| flag | output | 1 | Sticky capture/compare event flag |
| tmr_clr | output | 1 | One-cycle request to clear the timer |

## Verification
Capture is driven with single falling and single rising pulses. The timer value changes between pulses, so a store on the wrong edge, or one made a cycle early or late, shows up as a wrong `cap_val`. Pulse trains of 3, 4 and 16 rising edges separate the divide-by-4 and divide-by-16 counts from each other and from plain edge capture. A train that is interrupted by a mode change shows whether the prescale count is cleared. Compare is driven with matches lasting one cycle and several cycles, across all four actions, which separates level-triggered behaviour from first-cycle behaviour. The special-event match also checks that `tmr_clr` is a single pulse and that the pin is left alone.

// File: rtl/cap_cmp_unit.sv
module cap_cmp_unit #(
  parameter int TW   = 16,
  parameter int PS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_val,
  input  logic          pin_in,
  input  logic [3:0]    mode,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          flag_clr,
  output logic          pin_out,
  output logic [TW-1:0] cap_val,
  output logic [TW-1:0] cmp_val,
  output logic          flag,
  output logic          tmr_clr
);
  localparam logic [PS_W-1:0] PS_LAST4  = PS_W'(3);
  localparam logic [PS_W-1:0] PS_LAST16 = PS_W'(15);

  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_RISE = 4'b0101;
  localparam logic [3:0] M_CAP_R4   = 4'b0110;
  localparam logic [3:0] M_CAP_R16  = 4'b0111;
  localparam logic [3:0] M_CMP_SET  = 4'b1000;
  localparam logic [3:0] M_CMP_CLR  = 4'b1001;
  localparam logic [3:0] M_CMP_TGL  = 4'b1010;
  localparam logic [3:0] M_CMP_EVT  = 4'b1011;

  logic [2:0]      sync;
  logic [3:0]      mode_q;
  logic [PS_W-1:0] ps_cnt;
  logic            match_q;
  logic            cap_hit;

  wire rise     = sync[1] & ~sync[2];
  wire fall     = ~sync[1] & sync[2];
  wire is_cmp   = (mode[3:2] == 2'b10);
  wire ps_mode  = (mode == M_CAP_R4) || (mode == M_CAP_R16);
  wire match    = is_cmp && (tmr_val == cmp_val);
  wire cmp_hit  = match & ~match_q;

  always_comb begin
    case (mode)
      M_CAP_FALL: cap_hit = fall;
      M_CAP_RISE: cap_hit = rise;
      M_CAP_R4:   cap_hit = rise && (ps_cnt == PS_LAST4);
      M_CAP_R16:  cap_hit = rise && (ps_cnt == PS_LAST16);
      default:    cap_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= '0;
      mode_q  <= '0;
      ps_cnt  <= '0;
      match_q <= 1'b0;
      cap_val <= '0;
      cmp_val <= '0;
      pin_out <= 1'b0;
      flag    <= 1'b0;
      tmr_clr <= 1'b0;
    end else begin
      sync    <= {sync[1:0], pin_in};
      mode_q  <= mode;
      match_q <= match;

      if (mode != mode_q)
        ps_cnt <= '0;
      else if (ps_mode && rise)
        ps_cnt <= cap_hit ? '0 : ps_cnt + 1'b1;

      if (cap_hit)
        cap_val <= tmr_val;

      if (cmp_wr)
        cmp_val <= cmp_wdata;

      if (!is_cmp)
        pin_out <= 1'b0;
      else if (cmp_hit) begin
        case (mode)
          M_CMP_SET: pin_out <= 1'b1;
          M_CMP_CLR: pin_out <= 1'b0;
          M_CMP_TGL: pin_out <= ~pin_out;
          default:   pin_out <= pin_out;
        endcase
      end

      tmr_clr <= cmp_hit && (mode == M_CMP_EVT);
      flag    <= cap_hit | cmp_hit | (flag & ~flag_clr);
    end
  end
endmodule

module cap_cmp_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          flag_clr,
  input logic          pin_out,
  input logic [TW-1:0] cap_val,
  input logic          flag,
  input logic          tmr_clr
);
  a_r12_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b10) |=> !pin_out);

  a_r10_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !tmr_clr);

  a_r10_clr_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> flag);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  a_r2_cap_only_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |=> $stable(cap_val));

  a_r7_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b1000 && pin_out) |=> pin_out);
endmodule

bind cap_cmp_unit cap_cmp_unit_chk #(.TW(TW)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .flag_clr(flag_clr),
  .pin_out(pin_out), .cap_val(cap_val), .flag(flag), .tmr_clr(tmr_clr)
);

// File: tb/test_cap_cmp_unit.sv
module test_cap_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        pin_in = 1'b0;
  logic [3:0]  mode = '0;
  logic        cmp_wr = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        flag_clr = 1'b0;
  logic        pin_out, flag, tmr_clr;
  logic [15:0] cap_val, cmp_val;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cap_cmp_unit i_cap_cmp_unit (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .pin_in(pin_in), .mode(mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
    .pin_out(pin_out), .cap_val(cap_val), .cmp_val(cmp_val),
    .flag(flag), .tmr_clr(tmr_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode = m; cyc(2);
  endtask

  task automatic rise_pulse(input logic [15:0] t);
    tmr_val = t; pin_in = 1'b1; cyc(4); pin_in = 1'b0; cyc(4);
  endtask

  task automatic write_cmp(input logic [15:0] v);
    cmp_wdata = v; cmp_wr = 1'b1; cyc(1); cmp_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pin_out", pin_out, 0);
    check("R1 flag", flag, 0);
    check("R1 tmr_clr", tmr_clr, 0);
    check("R1 cap_val", cap_val, 0);
    check("R1 cmp_val", cmp_val, 0);
  endtask

  task automatic t_cap_edges();
    set_mode(4'b0100);
    tmr_val = 16'h1111; pin_in = 1'b1; cyc(4);
    check("R2 no capture on rise", cap_val, 0);
    check("R2 flag quiet on rise", flag, 0);
    tmr_val = 16'h2222; pin_in = 1'b0; cyc(2);
    check("R2 not yet", cap_val, 0);
    cyc(1);
    check("R2 falling capture", cap_val, 16'h2222);
    check("R2 flag", flag, 1);
    clear_flag();
    set_mode(4'b0101);
    tmr_val = 16'h3333; pin_in = 1'b1; cyc(3);
    check("R3 rising capture", cap_val, 16'h3333);
    check("R3 flag", flag, 1);
    clear_flag();
    tmr_val = 16'h4444; pin_in = 1'b0; cyc(4);
    check("R3 falling ignored", cap_val, 16'h3333);
    check("R11 cleared", flag, 0);
  endtask

  task automatic t_prescale();
    set_mode(4'b0110);
    for (int k = 0; k < 3; k++) rise_pulse(16'h0100 + 16'(k));
    check("R4 three edges no capture", cap_val, 16'h3333);
    check("R4 three edges no flag", flag, 0);
    rise_pulse(16'h0103);
    check("R4 fourth edge capture", cap_val, 16'h0103);
    check("R4 flag", flag, 1);
    clear_flag();
    set_mode(4'b0111);
    for (int k = 0; k < 15; k++) rise_pulse(16'h0200 + 16'(k));
    check("R5 fifteen edges no capture", cap_val, 16'h0103);
    check("R5 no flag", flag, 0);
    rise_pulse(16'h020F);
    check("R5 sixteenth edge capture", cap_val, 16'h020F);
    clear_flag();
    set_mode(4'b0110);
    rise_pulse(16'h0301); rise_pulse(16'h0302);
    set_mode(4'b0101);
    set_mode(4'b0110);
    rise_pulse(16'h0303); rise_pulse(16'h0304);
    check("R6 count cleared by mode change", cap_val, 16'h020F);
    check("R6 no flag", flag, 0);
    rise_pulse(16'h0305); rise_pulse(16'h0306);
    check("R6 capture after four new edges", cap_val, 16'h0306);
    clear_flag();
  endtask

  task automatic t_compare();
    tmr_val = 16'h7000;
    write_cmp(16'h0500);
    check("R13 compare write", cmp_val, 16'h0500);
    set_mode(4'b1000);
    check("R7 low before match", pin_out, 0);
    tmr_val = 16'h0500; cyc(1);
    check("R7 set on match", pin_out, 1);
    check("R7 flag", flag, 1);
    tmr_val = 16'h0501; cyc(1);
    clear_flag();
    mode = 4'b1001; cyc(2);
    check("R8 held before match", pin_out, 1);
    tmr_val = 16'h0500; cyc(1);
    check("R8 cleared on match", pin_out, 0);
    check("R8 flag", flag, 1);
    tmr_val = 16'h0501; cyc(1);
    clear_flag();
    mode = 4'b1010; cyc(2);
    tmr_val = 16'h0500; cyc(4);
    check("R9 single toggle on long match", pin_out, 1);
    tmr_val = 16'h0501; cyc(1);
    flag_clr = 1'b1; tmr_val = 16'h0500; cyc(1); flag_clr = 1'b0;
    check("R9 second toggle", pin_out, 0);
    check("R11 set wins over clear", flag, 1);
    tmr_val = 16'h0501; cyc(1);
    clear_flag();
    mode = 4'b1000; cyc(1);
    tmr_val = 16'h0500; cyc(1);
    tmr_val = 16'h0501;
    mode = 4'b1011; cyc(2);
    clear_flag();
    check("R10 no pulse idle", tmr_clr, 0);
    tmr_val = 16'h0500; cyc(1);
    check("R10 clear pulse", tmr_clr, 1);
    check("R10 flag", flag, 1);
    cyc(1);
    check("R10 pulse ends", tmr_clr, 0);
    check("R10 pin unchanged", pin_out, 1);
    tmr_val = 16'h0501; cyc(1);
    clear_flag();
  endtask

  task automatic t_off();
    mode = 4'b0000; cyc(1);
    check("R12 off drives low", pin_out, 0);
    tmr_val = 16'h0AAA; rise_pulse(16'h0AAA);
    check("R12 off no capture", cap_val, 16'h0306);
    check("R12 off no flag", flag, 0);
    mode = 4'b0011; cyc(1);
    rise_pulse(16'h0BBB);
    check("R12 unlisted no capture", cap_val, 16'h0306);
    check("R12 unlisted pin low", pin_out, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1; cyc(1);
    t_cap_edges();
    t_prescale();
    t_compare();
    t_off();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule